// File: doc/BRIEF.md
# Dual-Channel Setting Register Serial Controller

This block is the digital control core of a two-channel, 256-step setting device. A host talks to it over a four-wire serial link with a serial clock, a data input, a data output and an active-low select. Each transfer carries one 16-bit command word. The block keeps a live 8-bit setting for each channel, shown on the `setting` output. It also keeps an 8-bit shadow copy for each channel that stands in for non-volatile memory. Any operation that touches the shadow copy, and any readback, holds `rdy` low for a fixed busy time. The effect of the operation lands in the cycle in which that busy time ends.

All serial-side inputs are brought into the core clock domain through two-flop synchronizers and then edge-detected. The serial clock therefore has to stay at each level for at least three core clock cycles. A device whose shift register is not loaded with readback data passes the bits it received out again 16 serial clocks later, so several devices can be chained on one select line. A write-protect input blocks every command that would change a stored value. It does not block reloads from the shadow copy, and it does not block the hardware preset.

Word layout: bits 15:12 hold the command, bits 11:8 the channel address and bits 7:0 the data. Command codes: 0 no-op, 1 reload one channel from its shadow, 2 copy the live setting into the shadow, 3 write data into the shadow, 8 reload both channels, 9 read back the shadow, 10 read back the live setting, 11 write data into the live setting. Every other code is treated as a no-op.

Top module: `dwp_ctrl_top`

## Requirements
- R1: The data bit is taken on each rising edge of `sclk` while `cs_n` is low, most significant bit first. The command runs only after `cs_n` returns high, and only if exactly 16 rising edges were seen in that frame. Any other count discards the word.
- R2: Address 0 selects channel 1 (`setting[7:0]`) and address 1 selects channel 2 (`setting[15:8]`). A single-channel command carrying any other address has no effect.
- R3: Command 11 writes the data byte into the addressed live setting. Command 3 writes the data byte into the addressed shadow register. Command 2 copies the addressed live setting into its shadow register.
- R4: Command 1 reloads the addressed live setting from its shadow. Command 8 reloads both live settings from their shadows.
- R5: While the shift register is not loaded by a readback, `sdo` carries the bit stream received on `sdi`, delayed by 16 `sclk` rising edges. The current `sdo` level is the bit to be sampled before the next rising edge.
- R6: When command 9 (shadow) or command 10 (live) completes, the shift register is loaded with 0x00 in its upper byte and the addressed value in its lower byte. The next frame shifts this word out on `sdo`, MSB first.
- R7: While `wp_n` is low, commands 2, 3 and 11 change nothing. Commands 1, 8, 9, 10 and the preset still work.
- R8: A rising edge on `pr` reloads both live settings from their shadow registers.
- R9: After reset both live settings and both shadow registers hold 0x80, `rdy` is high and `sdo` is low.
- R10: Commands 2, 3, 8, 9, 10 and an accepted preset drive `rdy` low for `BUSY_CYC` core cycles. Their effect appears when `rdy` returns high.
- R11: While `rdy` is low, completed words and preset edges are ignored.
- R12: Command 0 and the unassigned command codes leave all settings unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| cs_n | input | 1 | Active-low frame select |
| wp_n | input | 1 | Active-low write protect |
| pr | input | 1 | Hardware preset, acts on its rising edge |
| sdo | output | 1 | Serial data out |
| rdy | output | 1 | High when idle, low while busy |
| setting | output | 16 | Live settings, channel 2 in the upper byte |

## Verification
A wrong value in a live setting shows on `setting` within a few core cycles of the frame that caused it. A wrong value in a shadow register stays hidden until a reload or a readback of command 9 brings it out, on `setting` or on `sdo` one frame later. A wrong bit in the shift register, or a wrong bit count, shows on `sdo` during the very next frame, because that frame shifts out the previous word. A busy timer that is off by a few cycles shows as `rdy` going high at the wrong time. A failure to ignore words while busy shows as a setting changing when it should not.

// File: rtl/dwp_pkg.sv
// Package: shared operation codes and command numbers for the setting controller.
// Assumes: a 4-bit command field; unlisted command codes act as no-ops.
package dwp_pkg;
    typedef enum logic [2:0] {
        OP_NONE, OP_LIVE_WR, OP_NV_WR, OP_STORE, OP_LOAD, OP_LOAD_ALL
    } op_e;

    typedef enum logic [1:0] {RB_NONE, RB_NV, RB_LIVE} rb_e;

    localparam logic [3:0] C_NOP     = 4'd0;
    localparam logic [3:0] C_LOAD1   = 4'd1;
    localparam logic [3:0] C_STORE   = 4'd2;
    localparam logic [3:0] C_NVWR    = 4'd3;
    localparam logic [3:0] C_LOADALL = 4'd8;
    localparam logic [3:0] C_RDNV    = 4'd9;
    localparam logic [3:0] C_RDLIVE  = 4'd10;
    localparam logic [3:0] C_LIVEWR  = 4'd11;
endpackage

// File: rtl/dwp_serial_rx.sv
// Module: serial front end. It synchronizes sclk, sdi and cs_n, shifts one bit on each
// sclk rising edge while selected, counts the bits and flags a complete word when the
// select is released. The same shift register drives sdo, which gives the 16-bit
// daisy-chain delay.
// Assumes: sclk holds each level for at least three clk cycles. A load is never
// requested in the same cycle as a shift.
module dwp_serial_rx #(
    parameter int WORD = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sclk,
    input  logic            sdi,
    input  logic            cs_n,
    input  logic            load_en,
    input  logic [WORD-1:0] load_val,
    output logic [WORD-1:0] word,
    output logic            word_ok,
    output logic            sdo
);
    localparam int CNTW = $clog2(WORD + 2);
    localparam logic [CNTW-1:0] CNT_FULL = CNTW'(WORD);
    localparam logic [CNTW-1:0] CNT_SAT  = CNTW'(WORD + 1);

    logic [2:0]      sclk_s;
    logic [2:0]      cs_s;
    logic [1:0]      sdi_s;
    logic [WORD-1:0] shreg;
    logic [CNTW-1:0] bitcnt;
    logic            sclk_rise;
    logic            cs_rise;

    // Bring the serial pins into the clk domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_s <= '0;
            cs_s   <= '1;
            sdi_s  <= '0;
        end else begin
            sclk_s <= {sclk_s[1:0], sclk};
            cs_s   <= {cs_s[1:0], cs_n};
            sdi_s  <= {sdi_s[0], sdi};
        end
    end

    assign sclk_rise = sclk_s[1] & ~sclk_s[2];
    assign cs_rise   = cs_s[1] & ~cs_s[2];

    // Shift register: parallel load for readback, serial shift while selected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (load_en) begin
            shreg <= load_val;
        end else if (sclk_rise && !cs_s[1]) begin
            shreg <= {shreg[WORD-2:0], sdi_s[1]};
        end
    end

    // Bit counter: cleared while deselected, saturates one past a full word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bitcnt <= '0;
        end else if (cs_s[1] && !cs_rise) begin
            bitcnt <= '0;
        end else if (sclk_rise && !cs_s[1] && bitcnt != CNT_SAT) begin
            bitcnt <= bitcnt + 1'b1;
        end
    end

    // Word strobe: raised for one cycle when a frame of exactly WORD bits closes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_ok <= 1'b0;
        end else begin
            word_ok <= cs_rise && (bitcnt == CNT_FULL);
        end
    end

    assign word = shreg;
    assign sdo  = shreg[WORD-1];

    a_r1_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        bitcnt <= CNT_SAT);
    a_r5_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_rise && !cs_s[1] && !load_en) |=> (shreg[0] == $past(sdi_s[1])));
endmodule

// File: rtl/dwp_regbank.sv
// Module: per-channel live setting and shadow registers. Each channel acts on a strobed
// operation from the executor; reload-all reaches every channel.
// Assumes: op_ch is already range-checked by the executor.
module dwp_regbank
    import dwp_pkg::*;
#(
    parameter int NCH = 2,
    parameter int DW  = 8,
    parameter logic [DW-1:0] MID = 8'h80,
    parameter int CHW = 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    op_stb,
    input  op_e                     op,
    input  logic [CHW-1:0]          op_ch,
    input  logic [DW-1:0]           op_data,
    output logic [NCH-1:0][DW-1:0]  live_q,
    output logic [NCH-1:0][DW-1:0]  nv_q
);
    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic hit;
        assign hit = op_stb && (int'(op_ch) == i);

        // Live setting: direct write, single reload or reload-all.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                live_q[i] <= MID;
            end else if (hit && op == OP_LIVE_WR) begin
                live_q[i] <= op_data;
            end else if ((hit && op == OP_LOAD) || (op_stb && op == OP_LOAD_ALL)) begin
                live_q[i] <= nv_q[i];
            end
        end

        // Shadow register: direct write or copy from the live setting.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                nv_q[i] <= MID;
            end else if (hit && op == OP_NV_WR) begin
                nv_q[i] <= op_data;
            end else if (hit && op == OP_STORE) begin
                nv_q[i] <= live_q[i];
            end
        end
    end

    a_r9_reset_mid: assert property (@(posedge clk)
        !rst_n |=> (live_q[0] == MID && nv_q[0] == MID));
endmodule

// File: rtl/dwp_exec.sv
// Module: command executor. It decodes completed words and preset edges, runs the busy
// timer for memory-related operations and readbacks, enforces write protection and
// ignores requests while busy.
// Assumes: wp_n and pr are asynchronous and are synchronized here.
module dwp_exec
    import dwp_pkg::*;
#(
    parameter int NCH      = 2,
    parameter int DW       = 8,
    parameter int WORD     = 16,
    parameter int BUSY_CYC = 8,
    parameter int CHW      = 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   word_ok,
    input  logic [WORD-1:0]        word,
    input  logic                   wp_n,
    input  logic                   pr,
    input  logic [NCH-1:0][DW-1:0] live_q,
    input  logic [NCH-1:0][DW-1:0] nv_q,
    output logic                   op_stb,
    output op_e                    op,
    output logic [CHW-1:0]         op_ch,
    output logic [DW-1:0]          op_data,
    output logic                   load_en,
    output logic [WORD-1:0]        load_val,
    output logic                   rdy
);
    localparam int BW = $clog2(BUSY_CYC + 1);
    localparam logic [BW-1:0] BUSY_LAST = BW'(BUSY_CYC - 1);

    typedef enum logic {ST_IDLE, ST_BUSY} st_e;

    st_e            state;
    logic [BW-1:0]  cnt;
    logic [1:0]     wp_s;
    logic [2:0]     pr_s;
    logic           wp_q;
    logic           pr_rise;
    op_e            pend_op;
    rb_e            pend_rb;
    logic [CHW-1:0] pend_ch;
    logic [DW-1:0]  pend_data;

    logic [3:0]     d_cmd;
    logic [3:0]     d_adr;
    logic           d_adr_ok;
    logic           d_imm;
    logic           d_busy;
    op_e            d_op;
    rb_e            d_rb;
    logic [DW-1:0]  rb_val;

    // Synchronize write protect and preset; detect the preset rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_s <= '1;
            pr_s <= '0;
        end else begin
            wp_s <= {wp_s[0], wp_n};
            pr_s <= {pr_s[1:0], pr};
        end
    end

    assign wp_q    = wp_s[1];
    assign pr_rise = pr_s[1] & ~pr_s[2];

    assign d_cmd    = word[WORD-1 -: 4];
    assign d_adr    = word[WORD-5 -: 4];
    assign d_adr_ok = int'(d_adr) < NCH;

    // Decode a completed word into an immediate or a busy operation.
    always_comb begin
        d_imm  = 1'b0;
        d_busy = 1'b0;
        d_op   = OP_NONE;
        d_rb   = RB_NONE;
        case (d_cmd)
            C_LOAD1:   if (d_adr_ok)         begin d_imm  = 1'b1; d_op = OP_LOAD;    end
            C_LIVEWR:  if (d_adr_ok && wp_q) begin d_imm  = 1'b1; d_op = OP_LIVE_WR; end
            C_STORE:   if (d_adr_ok && wp_q) begin d_busy = 1'b1; d_op = OP_STORE;   end
            C_NVWR:    if (d_adr_ok && wp_q) begin d_busy = 1'b1; d_op = OP_NV_WR;   end
            C_LOADALL:                       begin d_busy = 1'b1; d_op = OP_LOAD_ALL; end
            C_RDNV:    if (d_adr_ok)         begin d_busy = 1'b1; d_rb = RB_NV;      end
            C_RDLIVE:  if (d_adr_ok)         begin d_busy = 1'b1; d_rb = RB_LIVE;    end
            default: ;
        endcase
    end

    // Select the readback value for the pending channel.
    always_comb begin
        rb_val = (pend_rb == RB_NV) ? nv_q[pend_ch] : live_q[pend_ch];
    end

    // Control sequencer: accept work when idle, time the busy window, then apply it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            pend_op   <= OP_NONE;
            pend_rb   <= RB_NONE;
            pend_ch   <= '0;
            pend_data <= '0;
            op_stb    <= 1'b0;
            op        <= OP_NONE;
            op_ch     <= '0;
            op_data   <= '0;
            load_en   <= 1'b0;
            load_val  <= '0;
        end else begin
            op_stb  <= 1'b0;
            load_en <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (pr_rise) begin
                        state   <= ST_BUSY;
                        cnt     <= '0;
                        pend_op <= OP_LOAD_ALL;
                        pend_rb <= RB_NONE;
                    end else if (word_ok && d_imm) begin
                        op_stb  <= 1'b1;
                        op      <= d_op;
                        op_ch   <= d_adr[CHW-1:0];
                        op_data <= word[DW-1:0];
                    end else if (word_ok && d_busy) begin
                        state     <= ST_BUSY;
                        cnt       <= '0;
                        pend_op   <= d_op;
                        pend_rb   <= d_rb;
                        pend_ch   <= d_adr[CHW-1:0];
                        pend_data <= word[DW-1:0];
                    end
                end
                ST_BUSY: begin
                    if (cnt == BUSY_LAST) begin
                        state <= ST_IDLE;
                        if (pend_op != OP_NONE &&
                            (wp_q || pend_op == OP_LOAD_ALL || pend_op == OP_LOAD)) begin
                            op_stb  <= 1'b1;
                            op      <= pend_op;
                            op_ch   <= pend_ch;
                            op_data <= pend_data;
                        end
                        if (pend_rb != RB_NONE) begin
                            load_en  <= 1'b1;
                            load_val <= {{(WORD-DW){1'b0}}, rb_val};
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign rdy = (state == ST_IDLE);

    a_r7_wp_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (op_stb && !$past(wp_q)) |-> (op == OP_LOAD || op == OP_LOAD_ALL));
    a_r10_busy_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy && cnt == BUSY_LAST) |=> rdy);
    a_r10_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        !rdy |-> (cnt <= BUSY_LAST));
    a_r11_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy && cnt != BUSY_LAST) |=> (!rdy && !op_stb));
endmodule

// File: rtl/dwp_ctrl_top.sv
// Module: top level of the two-channel setting controller. It ties together the serial
// front end, the command executor and the register bank, and flattens the live settings
// onto one output bus.
// Assumes: one core clock; all serial and control inputs are asynchronous to it.
module dwp_ctrl_top
    import dwp_pkg::*;
#(
    parameter int NCH      = 2,
    parameter int DW       = 8,
    parameter int BUSY_CYC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              sdi,
    input  logic              cs_n,
    input  logic              wp_n,
    input  logic              pr,
    output logic              sdo,
    output logic              rdy,
    output logic [NCH*DW-1:0] setting
);
    localparam int WORD = 16;
    localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1;
    localparam logic [DW-1:0] MID = DW'(1 << (DW - 1));

    logic [WORD-1:0]        word;
    logic                   word_ok;
    logic                   load_en;
    logic [WORD-1:0]        load_val;
    logic                   op_stb;
    op_e                    op;
    logic [CHW-1:0]         op_ch;
    logic [DW-1:0]          op_data;
    logic [NCH-1:0][DW-1:0] live_q;
    logic [NCH-1:0][DW-1:0] nv_q;

    dwp_serial_rx #(.WORD(WORD)) u_rx (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdi(sdi), .cs_n(cs_n),
        .load_en(load_en), .load_val(load_val),
        .word(word), .word_ok(word_ok), .sdo(sdo)
    );

    dwp_exec #(.NCH(NCH), .DW(DW), .WORD(WORD), .BUSY_CYC(BUSY_CYC), .CHW(CHW)) u_exec (
        .clk(clk), .rst_n(rst_n), .word_ok(word_ok), .word(word),
        .wp_n(wp_n), .pr(pr), .live_q(live_q), .nv_q(nv_q),
        .op_stb(op_stb), .op(op), .op_ch(op_ch), .op_data(op_data),
        .load_en(load_en), .load_val(load_val), .rdy(rdy)
    );

    dwp_regbank #(.NCH(NCH), .DW(DW), .MID(MID), .CHW(CHW)) u_bank (
        .clk(clk), .rst_n(rst_n), .op_stb(op_stb), .op(op), .op_ch(op_ch),
        .op_data(op_data), .live_q(live_q), .nv_q(nv_q)
    );

    assign setting = live_q;
endmodule

// File: tb/tb_dwp_ctrl_top.sv
module tb_dwp_ctrl_top;
    localparam int BUSY = 150;
    localparam int GAP  = BUSY + 20;
    localparam int NV   = 19;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, sdi = 1'b0, cs_n = 1'b1, wp_n = 1'b1, pr = 1'b0;
    logic sdo, rdy;
    logic [15:0] setting;
    int total = 0, bad = 0;
    logic [15:0] cap;

    always #5 clk = ~clk;

    dwp_ctrl_top #(.NCH(2), .DW(8), .BUSY_CYC(BUSY)) dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdi(sdi), .cs_n(cs_n),
        .wp_n(wp_n), .pr(pr), .sdo(sdo), .rdy(rdy), .setting(setting)
    );

    // {word, wp_n, expected sdo capture, expected ch1, expected ch2}
    localparam logic [48:0] VEC [NV] = '{
        {16'h0000, 1'b1, 16'h0000, 8'h80, 8'h80},  // R12 nop
        {16'hB012, 1'b1, 16'h0000, 8'h12, 8'h80},  // R3 live write ch1
        {16'hB1A5, 1'b1, 16'hB012, 8'h12, 8'hA5},  // R2 R5
        {16'h9000, 1'b1, 16'hB1A5, 8'h12, 8'hA5},  // R6 read shadow ch1
        {16'h0000, 1'b1, 16'h0080, 8'h12, 8'hA5},  // R6 readback word
        {16'h2000, 1'b1, 16'h0000, 8'h12, 8'hA5},  // R3 store ch1
        {16'h3133, 1'b1, 16'h2000, 8'h12, 8'hA5},  // R3 shadow write ch2
        {16'hA100, 1'b1, 16'h3133, 8'h12, 8'hA5},  // R6 read live ch2
        {16'hB077, 1'b1, 16'h00A5, 8'h77, 8'hA5},  // R6 R3
        {16'h1000, 1'b1, 16'hB077, 8'h12, 8'hA5},  // R4 reload ch1
        {16'h8000, 1'b1, 16'h1000, 8'h12, 8'h33},  // R4 reload all
        {16'hB0FF, 1'b0, 16'h8000, 8'h12, 8'h33},  // R7 blocked
        {16'h3044, 1'b0, 16'hB0FF, 8'h12, 8'h33},  // R7 blocked
        {16'h9000, 1'b0, 16'h3044, 8'h12, 8'h33},  // R7 read allowed
        {16'hB1EE, 1'b0, 16'h0012, 8'h12, 8'h33},  // R7 shadow kept
        {16'hB155, 1'b1, 16'hB1EE, 8'h12, 8'h55},  // R3
        {16'h1100, 1'b0, 16'hB155, 8'h12, 8'h33},  // R7 reload allowed
        {16'hB2AA, 1'b1, 16'h1100, 8'h12, 8'h33},  // R2 bad address
        {16'h5000, 1'b1, 16'hB2AA, 8'h12, 8'h33}   // R12 unused code
    };

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input logic ok, input string tag, input logic [15:0] act,
                       input logic [15:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Send nbits of w, MSB first, capturing sdo before each rising sclk edge.
    task automatic frame(input logic [16:0] w, input int nbits);
        cap = '0;
        cs_n = 1'b0;
        for (int i = 0; i < nbits; i++) begin
            sdi = w[nbits-1-i];
            wait_clk(3);
            cap = {cap[14:0], sdo};
            sclk = 1'b1;
            wait_clk(3);
            sclk = 1'b0;
        end
        wait_clk(3);
        cs_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(2);
        // R9 reset state
        chk(setting == 16'h8080, "R9 settings", setting, 16'h8080);
        chk(rdy == 1'b1, "R9 rdy", {15'b0, rdy}, 16'h1);
        chk(sdo == 1'b0, "R9 sdo", {15'b0, sdo}, 16'h0);

        // Table walk: R1 R2 R3 R4 R5 R6 R7 R12
        for (int k = 0; k < NV; k++) begin
            wp_n = VEC[k][32];
            wait_clk(4);
            frame({1'b0, VEC[k][48:33]}, 16);
            wait_clk(GAP);
            chk(cap == VEC[k][31:16], $sformatf("R5 R6 sdo row %0d", k), cap, VEC[k][31:16]);
            chk(setting == {VEC[k][7:0], VEC[k][15:8]},
                $sformatf("R3 R4 R7 setting row %0d", k),
                setting, {VEC[k][7:0], VEC[k][15:8]});
        end
        wp_n = 1'b1;
        wait_clk(4);

        // R1 wrong bit counts discard the word
        frame(17'h0B0AB, 17);
        wait_clk(GAP);
        chk(setting[7:0] == 8'h12, "R1 17-bit frame", {8'h0, setting[7:0]}, 16'h0012);
        frame(17'h03055, 15);
        wait_clk(GAP);
        chk(setting[7:0] == 8'h12, "R1 15-bit frame", {8'h0, setting[7:0]}, 16'h0012);

        // R10 busy window; R11 word ignored while busy
        frame(17'h09000, 16);
        wait_clk(6);
        chk(rdy == 1'b0, "R10 rdy low", {15'b0, rdy}, 16'h0);
        frame(17'h0B0CC, 16);
        wait_clk(4);
        chk(rdy == 1'b0, "R11 still busy", {15'b0, rdy}, 16'h0);
        wait_clk(GAP);
        chk(rdy == 1'b1, "R10 rdy back", {15'b0, rdy}, 16'h1);
        chk(setting[7:0] == 8'h12, "R11 ignored write", {8'h0, setting[7:0]}, 16'h0012);
        frame(17'h00000, 16);
        wait_clk(GAP);
        chk(cap == 16'h0012, "R6 R11 readback", cap, 16'h0012);

        // R8 preset under write protect restores shadow values
        frame(17'h0B0FF, 16);
        wait_clk(GAP);
        chk(setting == 16'h33FF, "R3 pre-preset", setting, 16'h33FF);
        wp_n = 1'b0;
        wait_clk(4);
        pr = 1'b1;
        wait_clk(8);
        chk(rdy == 1'b0, "R10 preset busy", {15'b0, rdy}, 16'h0);
        pr = 1'b0;
        wait_clk(GAP);
        chk(setting == 16'h3312, "R8 R7 preset reload", setting, 16'h3312);
        wp_n = 1'b1;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule